// File: doc/BRIEF.md
# Reset-Time Option Configuration Loader

This block brings a small controller core out of reset. While the active-low reset input is held low, the core stays stopped and every configuration register is cleared. After reset is released, the block counts a programmable number of oscillator clocks so that the oscillator can settle. It then spends a fixed window of 512 oscillator clocks copying the 64-byte option page into internal configuration registers. That page sits at 1FC0h to 1FFFh, the last page of the 8 KiB program memory. When the window closes, the block pulses a program-counter clear and raises the run enable for the core.

Reads are paced at one per 8-clock slot, and the slots run from the lowest option address upward. The program memory answers each read one clock later. The configuration image is a flat vector that the option decoders downstream pick apart. A new reset at any point abandons the sequence and restarts it from the settling wait.

Top module: `opt_loader_top`

## Requirements
- R1: While rst_n is low, core_run_o, pc_zero_o and mem_rd_o are 0 and all 512 bits of opt_image_o are 0.
- R2: For the first STAB_CYCLES rising clock edges after rst_n goes high, mem_rd_o stays 0.
- R3: core_run_o rises exactly STAB_CYCLES + 512 rising edges after rst_n is released, and never earlier.
- R4: During loading, mem_rd_o is high for exactly one clock in each 8-clock slot (the slot's first clock), with mem_addr_o = 1FC0h + slot index, for slots 0 through 63 in ascending order.
- R5: The byte present on mem_data_i one clock after the read for slot k is stored in opt_image_o[8k+7:8k]; data present at any other time is not stored.
- R6: pc_zero_o is a single-clock pulse, high in the first clock in which core_run_o is high.
- R7: Once core_run_o is high, it stays high until rst_n goes low.
- R8: Driving rst_n low during the settling wait or the load window aborts the sequence; after release, the full settling wait and load window are repeated.
- R9: mem_rd_o is never high with mem_addr_o below 1FC0h, and never high in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd_o | output | 1 | Program-memory read strobe |
| mem_addr_o | output | 13 | Program-memory read address |
| mem_data_i | input | 8 | Read data, valid one clock after mem_rd_o |
| opt_image_o | output | 512 | Loaded option bytes; byte k at bits [8k+7:8k] |
| pc_zero_o | output | 1 | One-clock program-counter clear pulse |
| core_run_o | output | 1 | Core run enable |

## Verification
The bench targets the edges of the timeline. It checks the last clock of the wait, the first and last read of the window, and the clock on which the run enable rises. If a counter is off by one, the run enable rises a cycle early or late, or the first read lands in the wait. The bench also checks the capture slot. Its memory model drives a marker value on every cycle that is not a response, so a design that samples the data bus one clock too early or too late stores that marker rather than the option byte. Two aborts, one during the wait and one in mid-load, check that the image is cleared and that the full wait is timed again. A design that only paused would finish early and keep stale bytes.

// File: rtl/opt_loader_pkg.sv
package opt_loader_pkg;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_LOAD = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;

  // address of the read issued for a given slot
  function automatic logic [12:0] slot_addr(input logic [12:0] base, input logic [12:0] slot);
    return base + slot;
  endfunction

endpackage

// File: rtl/opt_phase_seq.sv
module opt_phase_seq
  import opt_loader_pkg::*;
#(
  parameter int STAB_CYCLES = 4096,
  parameter int LOAD_CYCLES = 512,
  localparam int MAXC = (STAB_CYCLES > LOAD_CYCLES) ? STAB_CYCLES : LOAD_CYCLES,
  localparam int CW = $clog2(MAXC) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output phase_e        phase_o,
  output logic [CW-1:0] cnt_o,
  output logic          load_done_o
);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic          wait_done;

  assign wait_done   = (phase_q == PH_WAIT) && (cnt_q == CW'(STAB_CYCLES - 1));
  assign load_done_o = (phase_q == PH_LOAD) && (cnt_q == CW'(LOAD_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_WAIT: begin
          if (wait_done) begin
            phase_q <= PH_LOAD;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_LOAD: begin
          if (load_done_o) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          phase_q <= PH_RUN;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;

  // R3
  load_window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOAD) |-> (cnt_q < CW'(LOAD_CYCLES)));

  // R2
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT) |-> (cnt_q < CW'(STAB_CYCLES)));

endmodule

// File: rtl/opt_fetch.sv
module opt_fetch
  import opt_loader_pkg::*;
#(
  parameter int          ADDR_W    = 13,
  parameter int          DATA_W    = 8,
  parameter int          NBYTES    = 64,
  parameter int          SLOT_CLKS = 8,
  parameter logic [12:0] BASE      = 13'h1FC0,
  localparam int SB  = $clog2(SLOT_CLKS),
  localparam int IW  = $clog2(NBYTES),
  localparam int LCW = SB + IW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     loading_i,
  input  logic [LCW-1:0]           cnt_i,
  output logic                     rd_o,
  output logic [ADDR_W-1:0]        addr_o,
  input  logic [DATA_W-1:0]        data_i,
  output logic [NBYTES*DATA_W-1:0] image_o
);

  logic [IW-1:0] slot;
  logic          cap_q;
  logic [IW-1:0] cap_idx_q;

  assign slot   = cnt_i[LCW-1:SB];
  assign rd_o   = loading_i && (cnt_i[SB-1:0] == '0);
  assign addr_o = ADDR_W'(slot_addr(BASE, 13'(slot)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q     <= 1'b0;
      cap_idx_q <= '0;
    end else begin
      cap_q     <= rd_o;
      cap_idx_q <= slot;
    end
  end

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) image_o[k*DATA_W +: DATA_W] <= '0;
      else if (cap_q && (cap_idx_q == IW'(k))) image_o[k*DATA_W +: DATA_W] <= data_i;
    end
  end

  // R9
  rd_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |-> (addr_o >= ADDR_W'(BASE)));

  // R9
  rd_not_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |=> !rd_o);

  // R5
  capture_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |=> (cap_q && cap_idx_q == $past(slot)));

endmodule

// File: rtl/opt_loader_top.sv
module opt_loader_top
  import opt_loader_pkg::*;
#(
  parameter int          STAB_CYCLES = 4096,
  parameter int          ADDR_W      = 13,
  parameter int          DATA_W      = 8,
  parameter int          NBYTES      = 64,
  parameter int          SLOT_CLKS   = 8,
  parameter logic [12:0] OPT_BASE    = 13'h1FC0,
  localparam int LOAD_CYCLES = NBYTES * SLOT_CLKS,
  localparam int LCW         = $clog2(LOAD_CYCLES),
  localparam int MAXC        = (STAB_CYCLES > LOAD_CYCLES) ? STAB_CYCLES : LOAD_CYCLES,
  localparam int CW          = $clog2(MAXC) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic                     mem_rd_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  input  logic [DATA_W-1:0]        mem_data_i,
  output logic [NBYTES*DATA_W-1:0] opt_image_o,
  output logic                     pc_zero_o,
  output logic                     core_run_o
);

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          load_done;
  logic          loading;
  logic          pcz_q;

  opt_phase_seq #(
    .STAB_CYCLES(STAB_CYCLES),
    .LOAD_CYCLES(LOAD_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_o    (phase),
    .cnt_o      (cnt),
    .load_done_o(load_done)
  );

  assign loading = (phase == PH_LOAD);

  opt_fetch #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NBYTES   (NBYTES),
    .SLOT_CLKS(SLOT_CLKS),
    .BASE     (OPT_BASE)
  ) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .loading_i(loading),
    .cnt_i    (cnt[LCW-1:0]),
    .rd_o     (mem_rd_o),
    .addr_o   (mem_addr_o),
    .data_i   (mem_data_i),
    .image_o  (opt_image_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcz_q <= 1'b0;
    else        pcz_q <= load_done;
  end

  assign pc_zero_o  = pcz_q;
  assign core_run_o = (phase == PH_RUN);

  // R6
  pc_zero_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run_o) |-> pc_zero_o);

  // R6
  pc_zero_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_zero_o |=> !pc_zero_o);

  // R7
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_run_o |=> core_run_o);

  // R2
  no_read_outside_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loading |-> !mem_rd_o);

endmodule

// File: tb/tb_opt_loader_top.sv
`timescale 1ns/1ps
module tb_opt_loader_top;

  localparam int S = 20;
  localparam int NB = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mem_rd;
  logic [12:0]  mem_addr;
  logic [7:0]   mem_data = 8'h00;
  logic [511:0] image;
  logic         pcz;
  logic         run;
  logic [7:0]   seed = 8'hA5;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  opt_loader_top #(.STAB_CYCLES(S)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_rd_o   (mem_rd),
    .mem_addr_o (mem_addr),
    .mem_data_i (mem_data),
    .opt_image_o(image),
    .pc_zero_o  (pcz),
    .core_run_o (run)
  );

  // memory: answers one clock after a read, marker value otherwise
  always @(posedge clk) mem_data <= mem_rd ? (mem_addr[7:0] ^ seed) : 8'hEE;

  // offsets from load start: expected read strobe and address (R4)
  localparam int NV = 8;
  localparam logic [31:0] V_OFF [NV] = '{0, 1, 7, 8, 9, 256, 504, 505};
  localparam logic        V_RD  [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [12:0] V_ADR [NV] = '{13'h1FC0, 13'h0, 13'h0, 13'h1FC1, 13'h0, 13'h1FE0, 13'h1FFF, 13'h0};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_byte(input int k, input logic [7:0] sd);
    logic [12:0] a;
    a = 13'h1FC0 + 13'(k);
    return a[7:0] ^ sd;
  endfunction

  task automatic check_reset_state(input string req);
    check(req, {63'd0, run}, 64'd0);
    check(req, {63'd0, pcz}, 64'd0);
    check(req, {63'd0, mem_rd}, 64'd0);
    check(req, {63'd0, (image == '0)}, 64'd1);
  endtask

  // from release (at a negedge), verify wait, window, start pulse and image
  task automatic full_sequence(input logic [7:0] sd);
    int rd_seen;
    int pos;
    seed = sd;
    rst_n = 1'b1;
    rd_seen = 0;
    for (int i = 0; i < S; i++) begin
      if (mem_rd) rd_seen++;
      step(1);
    end
    check("R2 no read during wait", 64'(rd_seen), 64'd0);
    pos = 0;
    for (int v = 0; v < NV; v++) begin
      step(int'(V_OFF[v]) - pos);
      pos = int'(V_OFF[v]);
      check("R4 read strobe", {63'd0, mem_rd}, {63'd0, V_RD[v]});
      if (V_RD[v]) check("R4 read address", 64'(mem_addr), 64'(V_ADR[v]));
    end
    step(511 - pos);
    check("R3 run not before window end", {63'd0, run}, 64'd0);
    step(1);
    check("R3 run rises at window end", {63'd0, run}, 64'd1);
    check("R6 pc clear pulse", {63'd0, pcz}, 64'd1);
    step(1);
    check("R6 pc clear single clock", {63'd0, pcz}, 64'd0);
    check("R7 run held", {63'd0, run}, 64'd1);
    for (int k = 0; k < NB; k++)
      check("R5 option byte", 64'(image[k*8 +: 8]), 64'(exp_byte(k, sd)));
    step(30);
    check("R7 run held later", {63'd0, run}, 64'd1);
    check("R9 no reads while running", {63'd0, mem_rd}, 64'd0);
  endtask

  initial begin
    #2_000_000;
    checks++;
    failures++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    check_reset_state("R1 reset state");
    full_sequence(8'hA5);

    // abort in the middle of the load window (R8)
    rst_n = 1'b0;
    step(2);
    check_reset_state("R1 R8 reset after run");
    rst_n = 1'b1;
    step(S + 100);
    rst_n = 1'b0;
    step(1);
    check_reset_state("R8 abort mid-load clears");
    full_sequence(8'h3C);

    // abort during the settling wait (R8)
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(S - 3);
    rst_n = 1'b0;
    step(1);
    check_reset_state("R8 abort in wait");
    full_sequence(8'h5A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule